// File: doc/BRIEF.md
# Chained FIFO Slice with Ring-Passed Ownership

This block builds a deep first-in/first-out buffer from identical slices. Each slice has its own small storage array, its own read and write pointers and its own active-low empty and full flags. All slices see the same write strobe, write data and read strobe. At any moment only one slice holds the right to accept writes and only one holds the right to return reads. A slice gives up a right when it uses its last physical location, and it hands that right to the next slice with a one-cycle expansion pulse. Write hand-offs and read hand-offs travel on separate lines. The last slice feeds the first, so the chain closes into a ring and holds `SLICES*DEPTH` words.

Each slice runs a four-state ownership machine. `TK_NONE` holds no right. `TK_WRITE` holds only the write right. `TK_READ` holds only the read right. `TK_BOTH` holds both. The state moves on four events. Take-write and take-read are incoming expansion pulses. Give-write is an accepted write to the last location. Give-read is an accepted read from the last location. After reset the first-load slice (index 0) starts in `TK_BOTH` and every other slice starts in `TK_NONE`. The top level forms the composite flags from the per-slice flags.

A standalone input keeps slice 0 working on its own as a single buffer of `DEPTH` words. In that mode slice 0 never hands off either right, and its flags drive the outputs directly.

Top module: `fifo_chain`

## Requirements
- R1: During and after reset, `empty_n`=0, `full_n`=1 and `rd_valid`=0. Both `wr_tok` and `rd_tok` equal 1, meaning slice 0 holds both rights.
- R2: The words come out in the order they were written, across slice boundaries. An accepted read in a cycle shows `rd_valid`=1 and the word on `rd_data` after the next rising edge. With no accepted read, `rd_valid` is 0.
- R3: An accepted write to location `DEPTH-1` of the slice holding the write right moves the set bit of `wr_tok` from slice k to slice k+1 at that same edge.
- R4: An accepted read from location `DEPTH-1` of the slice holding the read right moves the set bit of `rd_tok` from slice k to slice k+1 at that same edge.
- R5: The last slice hands each right back to slice 0, so the ring accepts exactly `SLICES*DEPTH` words before it reports full.
- R6: `full_n` is 0 only when every slice is full, that is when the buffer holds `SLICES*DEPTH` words. `empty_n` is 0 only when every slice is empty.
- R7: A write while `full_n`=0 is ignored. The stored words and `wr_tok` are unchanged.
- R8: A read while `empty_n`=0 is ignored. `rd_valid` stays 0 and `rd_tok` is unchanged.
- R9: When the buffer is neither empty nor full, a read and a write in the same cycle both take effect, including across a hand-off.
- R10: With `solo`=1 held through reset, slice 0 keeps both rights (`wr_tok`=`rd_tok`=1). Full is reached after `DEPTH` words, and order is kept as its pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| solo | input | 1 | Standalone single-slice mode; change only during reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |
| wr_tok | output | SLICES | One-hot owner of the write right |
| rd_tok | output | SLICES | One-hot owner of the read right |

## Verification
The assertions assume that `solo` changes only while reset is held. They also assume that a hand-off pulse reaches a slice only from its ring neighbour, so that exactly one write owner and one read owner exist from the first cycle after reset. The stimulus sets `solo` before asserting reset and never changes it afterwards. It drives the strobes only between clock edges. Reads on an empty buffer and writes on a full buffer are issued on purpose, so the hold assertions on the flags are exercised rather than avoided.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    typedef enum logic [1:0] {
        TK_NONE  = 2'b00,
        TK_WRITE = 2'b01,
        TK_READ  = 2'b10,
        TK_BOTH  = 2'b11
    } tok_state_t;

    function automatic tok_state_t tok_join(input logic keep_w, input logic keep_r);
        tok_state_t s;
        case ({keep_r, keep_w})
            2'b00:   s = TK_NONE;
            2'b01:   s = TK_WRITE;
            2'b10:   s = TK_READ;
            default: s = TK_BOTH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slice_ram.sv
module slice_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/chain_slice.sv
module chain_slice
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             solo,
    input  logic             fl_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr,
    output logic             xo_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty_n,
    output logic             full_n,
    output logic             has_wr,
    output logic             has_rd
);
    localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAPCNT = CW'(DEPTH);

    tok_state_t      state, state_nxt;
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   count;
    logic            wr_ok, rd_ok, take_w, take_r;

    // Output process: rights, acceptance, hand-off pulses, flags
    always_comb begin
        has_wr  = (state == TK_WRITE) || (state == TK_BOTH);
        has_rd  = (state == TK_READ)  || (state == TK_BOTH);
        wr_ok   = wr_en && has_wr && (count != CAPCNT);
        rd_ok   = rd_en && has_rd && (count != '0);
        xo_wr   = wr_ok && (wptr == LAST) && !solo;
        xo_rd   = rd_ok && (rptr == LAST) && !solo;
        take_w  = xi_wr && !solo;
        take_r  = xi_rd && !solo;
        empty_n = (count != '0);
        full_n  = (count != CAPCNT);
    end

    // Next-state process
    always_comb begin
        state_nxt = state;
        unique case (state)
            TK_NONE:  state_nxt = tok_join(take_w, take_r);
            TK_WRITE: state_nxt = tok_join(!xo_wr || take_w, take_r);
            TK_READ:  state_nxt = tok_join(take_w, !xo_rd || take_r);
            TK_BOTH:  state_nxt = tok_join(!xo_wr || take_w, !xo_rd || take_r);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= fl_n ? TK_NONE : TK_BOTH;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            count    <= count + CW'(wr_ok) - CW'(rd_ok);
            rd_valid <= rd_ok;
        end
    end

    slice_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wptr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (rptr),
        .rdata (rd_data)
    );

    // R3: giving the write right drops it; an incoming pulse grants it
    a_r3_give_write: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_wr && !xi_wr) |=> !has_wr);
    a_r3_take_write: assert property (@(posedge clk) disable iff (!rst_n)
        (xi_wr && !solo) |=> has_wr);
    // R4: same for the read right
    a_r4_give_read: assert property (@(posedge clk) disable iff (!rst_n)
        (xo_rd && !xi_rd) |=> !has_rd);
    a_r4_take_read: assert property (@(posedge clk) disable iff (!rst_n)
        (xi_rd && !solo) |=> has_rd);
    // R7: a full slice stays full unless it is read
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !(rd_en && has_rd)) |=> !full_n);
    // R8: an empty slice stays empty unless it is written
    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !(wr_en && has_wr)) |=> !empty_n);
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain #(
    parameter int WIDTH  = 9,
    parameter int DEPTH  = 4,
    parameter int SLICES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              solo,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic [SLICES-1:0] wr_tok,
    output logic [SLICES-1:0] rd_tok
);
    logic [SLICES-1:0] xo_wr, xo_rd, xi_wr, xi_rd;
    logic [SLICES-1:0] vld_s, emp_s, ful_s;
    logic [WIDTH-1:0]  dat_s [SLICES];

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
        assign xi_wr[i] = xo_wr[PREV];
        assign xi_rd[i] = xo_rd[PREV];

        chain_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .solo     (solo),
            .fl_n     (i != 0),
            .wr_en    (wr_en),
            .wr_data  (wr_data),
            .rd_en    (rd_en),
            .xi_wr    (xi_wr[i]),
            .xi_rd    (xi_rd[i]),
            .xo_wr    (xo_wr[i]),
            .xo_rd    (xo_rd[i]),
            .rd_data  (dat_s[i]),
            .rd_valid (vld_s[i]),
            .empty_n  (emp_s[i]),
            .full_n   (ful_s[i]),
            .has_wr   (wr_tok[i]),
            .has_rd   (rd_tok[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLICES; i++)
            if (vld_s[i]) rd_data = rd_data | dat_s[i];
        rd_valid = |vld_s;
        // Active-low flags: OR means every slice asserts
        empty_n  = solo ? emp_s[0] : |emp_s;
        full_n   = solo ? ful_s[0] : |ful_s;
    end

    // R5: exactly one owner of each right around the ring
    a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wr_tok));
    a_r5_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rd_tok));
    // R2: data valid only after a read request
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));
    // R6: never both empty and full
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));
    // R10: standalone mode keeps both rights on slice 0
    a_r10_solo_home: assert property (@(posedge clk) disable iff (!rst_n)
        solo |-> (wr_tok[0] && rd_tok[0]));
endmodule

// File: tb/tb_fifo_chain.sv
module tb_fifo_chain;
    localparam int WIDTH  = 9;
    localparam int DEPTH  = 4;
    localparam int SLICES = 3;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              solo = 0;
    logic              wr_en = 0;
    logic [WIDTH-1:0]  wr_data = '0;
    logic              rd_en = 0;
    logic [WIDTH-1:0]  rd_data;
    logic              rd_valid, empty_n, full_n;
    logic [SLICES-1:0] wr_tok, rd_tok;

    int total = 0;
    int bad = 0;
    int wtot = 0, rtot = 0, cap = SLICES * DEPTH;
    logic [WIDTH-1:0] mq [$];

    always #2 clk = ~clk;

    fifo_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SLICES(SLICES)) dut (
        .clk(clk), .rst_n(rst_n), .solo(solo), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n),
        .full_n(full_n), .wr_tok(wr_tok), .rd_tok(rd_tok)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        solo = s; rst_n = 0; wr_en = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mq.delete(); wtot = 0; rtot = 0;
        cap = s ? DEPTH : SLICES * DEPTH;
    endtask

    // One cycle of stimulus; checks outputs after the edge against the model
    task automatic step(input logic we, input logic re, input logic [WIDTH-1:0] d);
        bit wacc, racc;
        logic [WIDTH-1:0] exp_d;
        int sz;
        @(negedge clk);
        wr_en = we; rd_en = re; wr_data = d;
        sz = mq.size();
        wacc = we && (sz < cap);
        racc = re && (sz > 0);
        exp_d = racc ? mq[0] : '0;
        @(posedge clk); #1;
        if (racc) begin void'(mq.pop_front()); rtot++; end
        if (wacc) begin mq.push_back(d); wtot++; end
        if (racc) begin
            chk(rd_valid === 1'b1, "R2 rd_valid", int'(rd_valid), 1);
            chk(rd_data === exp_d, "R2 rd_data", int'(rd_data), int'(exp_d));
        end else begin
            chk(rd_valid === 1'b0, re ? "R8 read on empty" : "R2 idle valid", int'(rd_valid), 0);
        end
        chk(wr_tok === SLICES'(1 << ((wtot % cap) / DEPTH)), "R3 wr_tok",
            int'(wr_tok), 1 << ((wtot % cap) / DEPTH));
        chk(rd_tok === SLICES'(1 << ((rtot % cap) / DEPTH)), "R4 rd_tok",
            int'(rd_tok), 1 << ((rtot % cap) / DEPTH));
        chk(empty_n === (mq.size() != 0), "R6 empty_n", int'(empty_n), int'(mq.size() != 0));
        chk(full_n === (mq.size() != cap), "R6 full_n", int'(full_n), int'(mq.size() != cap));
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic t_reset();
        do_reset(0);
        #1;
        chk(empty_n === 1'b0, "R1 empty_n", int'(empty_n), 0);
        chk(full_n === 1'b1, "R1 full_n", int'(full_n), 1);
        chk(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(wr_tok === 3'b001, "R1 wr_tok", int'(wr_tok), 1);
        chk(rd_tok === 3'b001, "R1 rd_tok", int'(rd_tok), 1);
    endtask

    task automatic t_fill_drain();
        do_reset(0);
        for (int i = 0; i < SLICES * DEPTH; i++) begin
            step(1, 0, WIDTH'(9'h40 + i));
            if (i == DEPTH - 1) chk(wr_tok === 3'b010, "R3 hand-off", int'(wr_tok), 2);
            if (i == SLICES * DEPTH - 2) chk(full_n === 1'b1, "R6 not yet full", int'(full_n), 1);
        end
        chk(full_n === 1'b0, "R5 full at capacity", int'(full_n), 0);
        chk(wr_tok === 3'b001, "R5 wrap to slice 0", int'(wr_tok), 1);
        step(1, 0, 9'h1FF);
        chk(wr_tok === 3'b001, "R7 wr_tok unchanged", int'(wr_tok), 1);
        for (int i = 0; i < SLICES * DEPTH; i++) begin
            step(0, 1, '0);
            if (i == DEPTH - 1) chk(rd_tok === 3'b010, "R4 hand-off", int'(rd_tok), 2);
        end
        chk(empty_n === 1'b0, "R6 empty after drain", int'(empty_n), 0);
        chk(rd_tok === 3'b001, "R5 read wrap", int'(rd_tok), 1);
        step(0, 1, '0);
        chk(rd_tok === 3'b001, "R8 rd_tok unchanged", int'(rd_tok), 1);
    endtask

    task automatic t_simultaneous();
        do_reset(0);
        step(1, 0, 9'h011);
        step(1, 0, 9'h022);
        for (int i = 0; i < 8; i++) step(1, 1, WIDTH'(9'h080 + i));
        chk(mq.size() == 2, "R9 occupancy kept", mq.size(), 2);
        chk(wr_tok === 3'b100, "R9 writer moved", int'(wr_tok), 4);
        while (mq.size() != 0) step(0, 1, '0);
        chk(rd_tok === 3'b100, "R9 reader moved", int'(rd_tok), 4);
    endtask

    task automatic t_solo();
        do_reset(1);
        for (int i = 0; i < DEPTH; i++) step(1, 0, WIDTH'(9'h100 + i));
        chk(full_n === 1'b0, "R10 solo full", int'(full_n), 0);
        chk(wr_tok === 3'b001, "R10 solo writer", int'(wr_tok), 1);
        step(0, 1, '0);
        step(0, 1, '0);
        step(1, 0, 9'h155);
        step(1, 0, 9'h166);
        while (mq.size() != 0) step(0, 1, '0);
        chk(rd_tok === 3'b001, "R10 solo reader", int'(rd_tok), 1);
        chk(empty_n === 1'b0, "R10 solo empty", int'(empty_n), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_simultaneous();
        t_solo();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule